// File: doc/BRIEF.md
# Fixed-Priority Slave Port Arbiter

This block decides which of several bus masters owns one slave port of a multi-master crossbar. Each master has a hardwired, unique 3-bit priority level. The arbiter re-examines ownership on every clock edge and drives a one-hot grant vector, together with the owner's index and a valid flag. The address path, the data path and the slave protocol sit outside this block. Those parts use the owner index to steer their multiplexers.

Ownership changes only at a transfer boundary, which the slave signals with a done strobe. A master that outranks the owner takes over when the owner's current single transfer terminates. A master that ranks lower keeps waiting for as long as the owner goes on requesting. A burst of fixed length, announced on its first beat, is never broken up. When ownership moves from one master to another, the grant stays low for exactly one cycle before the new master receives it. An owner that keeps winning runs transfers back to back with no idle cycles.

Top module: `xbar_slave_arbiter`

## Requirements
- R1: When the port is free and masters request, the master with the highest rank is granted. With the default polarity the numerically larger level ranks higher. The default levels are 7 for master 0, 6 for master 1 and 5 for master 2, so the lowest-numbered requester wins.
- R2: A request to a free port is granted on the clock edge that follows it. With no request pending, `grant` is all zeros and `owner_valid` is 0.
- R3: `grant` has at most one bit set. While `owner_valid` is 1, the set bit is bit `owner_idx`.
- R4: While `xfer_done` is low, the owner keeps the grant, whatever the other masters request.
- R5: At the `xfer_done` that ends a single transfer, a requester that outranks the owner causes the grant to drop to zero for exactly one cycle. On the next edge the highest-ranked requester is then granted.
- R6: An owner that still requests and still ranks highest keeps the grant through consecutive `xfer_done` cycles, with no idle cycle between them.
- R7: A lower-ranked requester waits for as long as the owner keeps requesting. Once the owner stops requesting at a transfer end, the grant idles for one cycle and then passes to the waiting master.
- R8: A burst is announced by the owner's `burst_start` bit, with its length L taken from the owner's `burst_len` field (bits `[i*LEN_W +: LEN_W]` for master i), at the `xfer_done` of the first beat. If L >= 2, the owner keeps the grant through all L beats, including wait cycles, regardless of higher-ranked requesters. Arbitration resumes at the L-th `xfer_done`.
- R9: A burst length of 0 or 1 is treated as a single transfer.
- R10: During and right after reset, `grant` is zero and `owner_valid` is 0.
- R11: With `HIGH_WINS` = 0 the polarity is reversed: the numerically smaller level wins. With the default levels, the highest-numbered requester wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | N_MASTERS | Per-master request |
| burst_start | input | N_MASTERS | Current beat is the first beat of a fixed-length burst |
| burst_len | input | N_MASTERS*LEN_W | Per-master burst length in beats |
| xfer_done | input | 1 | Slave completes the current beat this cycle |
| grant | output | N_MASTERS | One-hot grant |
| owner_idx | output | IDX_W | Index of the current owner |
| owner_valid | output | 1 | The port is currently owned |

## Verification
All outputs are registered, so each result appears one edge after its stimulus. A request to a free port shows its grant after one edge. A takeover shows a zero grant after the done edge and the new owner after the edge that follows. The bench drives inputs on the falling edge, lets exactly one rising edge pass, and compares at the next falling edge against a winner computed from the request mask. It sweeps every request mask for both polarities, every owner/challenger combination for takeovers, and burst lengths 0 through 5.

// File: rtl/xbar_arb_pkg.sv
// Package: shared types for the slave port arbiter.
// Assumes nothing beyond IEEE 1800-2017 synthesizable constructs.
package xbar_arb_pkg;

    // Ownership state of the slave port
    typedef enum logic {
        PORT_FREE = 1'b0,
        PORT_HELD = 1'b1
    } port_state_e;

endpackage

// File: rtl/spa_prio_pick.sv
// Module: spa_prio_pick
// Combinational selection of the highest-ranked requester.
// Assumes every master has a distinct level, so the winner is unique.
// HIGH_WINS picks whether a larger or a smaller level ranks higher.
module spa_prio_pick #(
    parameter int N_MASTERS = 3,
    parameter int PRIO_W    = 3,
    parameter logic [N_MASTERS*PRIO_W-1:0] PRIO_LEVELS = {3'd5, 3'd6, 3'd7},
    parameter bit HIGH_WINS = 1'b1,
    localparam int IDX_W    = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
    input  logic [N_MASTERS-1:0] req,
    output logic                 win_valid,
    output logic [IDX_W-1:0]     win_idx
);

    logic [PRIO_W-1:0] rank [N_MASTERS];

    // Per-master rank: the level itself, or its complement for reversed polarity
    for (genvar g = 0; g < N_MASTERS; g++) begin : g_rank
        if (HIGH_WINS) begin : g_hi
            assign rank[g] = PRIO_LEVELS[g*PRIO_W +: PRIO_W];
        end else begin : g_lo
            assign rank[g] = ~PRIO_LEVELS[g*PRIO_W +: PRIO_W];
        end
    end

    logic [PRIO_W-1:0] best_rank;

    // Scan the requesters and keep the one with the largest rank
    always_comb begin
        win_valid = 1'b0;
        win_idx   = '0;
        best_rank = '0;
        for (int i = 0; i < N_MASTERS; i++) begin
            if (req[i] && (!win_valid || rank[i] > best_rank)) begin
                win_valid = 1'b1;
                win_idx   = IDX_W'(i);
                best_rank = rank[i];
            end
        end
    end

endmodule

// File: rtl/spa_burst_track.sv
// Module: spa_burst_track
// Counts the beats of the owner's fixed-length burst and flags the beat
// whose completion ends the owner's transfer.
// Assumes: a burst is announced at the done of its first beat; clear is high
// whenever the port has no owner.
module spa_burst_track #(
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             beat_done,
    input  logic             start,
    input  logic [LEN_W-1:0] len,
    output logic             in_burst,
    output logic             xfer_end
);

    logic [LEN_W-1:0] remain;
    logic             long_start;

    // A burst only matters if it has more than one beat
    assign long_start = start && (len > LEN_W'(1));

    // The transfer ends on a single beat, or on the final beat of a burst
    assign xfer_end = beat_done && (in_burst ? (remain == LEN_W'(1)) : !long_start);

    // Load the count on the first beat and decrement it on each later beat
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            in_burst <= 1'b0;
            remain   <= '0;
        end else if (beat_done) begin
            if (in_burst) begin
                if (remain == LEN_W'(1)) begin
                    in_burst <= 1'b0;
                    remain   <= '0;
                end else begin
                    remain <= remain - LEN_W'(1);
                end
            end else if (long_start) begin
                in_burst <= 1'b1;
                remain   <= len - LEN_W'(1);
            end
        end
    end

    // R8
    burst_count_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_burst |-> remain != '0);

    // R8
    burst_continues_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_burst && beat_done && !clear && remain > LEN_W'(1)) |=> in_burst);

endmodule

// File: rtl/xbar_slave_arbiter.sv
// Module: xbar_slave_arbiter
// Fixed-priority ownership of one crossbar slave port. Re-arbitrates on
// every edge. The owner is replaced only at the end of a transfer (never inside
// a burst), and a change of owner always passes through one free cycle.
// Assumes distinct levels and that xfer_done is meaningful only while owned.
module xbar_slave_arbiter
    import xbar_arb_pkg::*;
#(
    parameter int N_MASTERS = 3,
    parameter int PRIO_W    = 3,
    parameter int LEN_W     = 4,
    parameter logic [N_MASTERS*PRIO_W-1:0] PRIO_LEVELS = {3'd5, 3'd6, 3'd7},
    parameter bit HIGH_WINS = 1'b1,
    localparam int IDX_W    = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N_MASTERS-1:0]       req,
    input  logic [N_MASTERS-1:0]       burst_start,
    input  logic [N_MASTERS*LEN_W-1:0] burst_len,
    input  logic                       xfer_done,
    output logic [N_MASTERS-1:0]       grant,
    output logic [IDX_W-1:0]           owner_idx,
    output logic                       owner_valid
);

    port_state_e      state;
    logic             win_valid;
    logic [IDX_W-1:0] win_idx;
    logic             own_req;
    logic             own_start;
    logic [LEN_W-1:0] own_len;
    logic             in_burst;
    logic             xfer_end;
    logic             keep_owner;

    spa_prio_pick #(
        .N_MASTERS  (N_MASTERS),
        .PRIO_W     (PRIO_W),
        .PRIO_LEVELS(PRIO_LEVELS),
        .HIGH_WINS  (HIGH_WINS)
    ) u_pick (
        .req      (req),
        .win_valid(win_valid),
        .win_idx  (win_idx)
    );

    // Select the current owner's request and burst fields
    always_comb begin
        own_req   = 1'b0;
        own_start = 1'b0;
        own_len   = '0;
        for (int i = 0; i < N_MASTERS; i++) begin
            if (owner_idx == IDX_W'(i)) begin
                own_req   = req[i];
                own_start = burst_start[i];
                own_len   = burst_len[i*LEN_W +: LEN_W];
            end
        end
    end

    spa_burst_track #(
        .LEN_W(LEN_W)
    ) u_burst (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (state == PORT_FREE),
        .beat_done(state == PORT_HELD && xfer_done),
        .start    (own_start),
        .len      (own_len),
        .in_burst (in_burst),
        .xfer_end (xfer_end)
    );

    // The owner stays on only if it still requests and is still the winner
    assign keep_owner = own_req && win_valid && (win_idx == owner_idx);

    // Ownership register: claim a free port, release it at a lost transfer end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= PORT_FREE;
            owner_idx <= '0;
        end else if (state == PORT_FREE) begin
            if (win_valid) begin
                state     <= PORT_HELD;
                owner_idx <= win_idx;
            end
        end else if (xfer_end && !keep_owner) begin
            state <= PORT_FREE;
        end
    end

    assign owner_valid = (state == PORT_HELD);

    // Decode the owner index into the one-hot grant
    always_comb begin
        grant = '0;
        if (owner_valid) begin
            for (int i = 0; i < N_MASTERS; i++) begin
                grant[i] = (owner_idx == IDX_W'(i));
            end
        end
    end

    // R2
    idle_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!owner_valid && (req != '0)) |=> owner_valid);

    // R1
    claim_was_requested_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(owner_valid) |-> (($past(req) & grant) != '0));

    // R4
    hold_until_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (owner_valid && !xfer_done) |=> (owner_valid && $stable(owner_idx)));

    // R5
    handoff_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (owner_valid && $past(owner_valid)) |-> (owner_idx == $past(owner_idx)));

    // R8
    burst_no_preempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (owner_valid && in_burst && !xfer_end) |=> owner_valid);

endmodule

// File: tb/xbar_slave_arbiter_tb.sv
module xbar_slave_arbiter_tb;

    localparam int N     = 3;
    localparam int LEN_W = 4;
    localparam int IDX_W = 2;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [N-1:0]     req;
    logic [N-1:0]     burst_start;
    logic [N*LEN_W-1:0] burst_len;
    logic             xfer_done;
    logic [N-1:0]     grant, grant_inv;
    logic [IDX_W-1:0] owner_idx, owner_idx_inv;
    logic             owner_valid, owner_valid_inv;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    xbar_slave_arbiter u_dut (
        .clk(clk), .rst_n(rst_n), .req(req), .burst_start(burst_start),
        .burst_len(burst_len), .xfer_done(xfer_done), .grant(grant),
        .owner_idx(owner_idx), .owner_valid(owner_valid)
    );

    xbar_slave_arbiter #(.HIGH_WINS(1'b0)) u_inv (
        .clk(clk), .rst_n(rst_n), .req(req), .burst_start(burst_start),
        .burst_len(burst_len), .xfer_done(xfer_done), .grant(grant_inv),
        .owner_idx(owner_idx_inv), .owner_valid(owner_valid_inv)
    );

    // Default levels 7,6,5: the lowest set bit wins
    function automatic int low_bit(input logic [N-1:0] m);
        for (int i = N - 1; i >= 0; i--) if (m[i]) low_bit = i;
    endfunction

    // Reversed polarity: the highest set bit wins
    function automatic int high_bit(input logic [N-1:0] m);
        for (int i = 0; i < N; i++) if (m[i]) high_bit = i;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic go_idle();
        req = '0; burst_start = '0; xfer_done = 1'b1;
        step();
        xfer_done = 1'b0;
        step();
    endtask

    task automatic acquire(input int m);
        go_idle();
        req = N'(1 << m);
        step();
    endtask

    initial begin
        rst_n = 1'b0; req = '0; burst_start = '0; burst_len = '0; xfer_done = 1'b0;
        repeat (3) step();
        chk("R10 grant in reset", int'(grant), 0);
        chk("R10 valid in reset", int'(owner_valid), 0);
        rst_n = 1'b1;
        step();
        chk("R10 grant after reset", int'(grant), 0);

        // R2: nobody requests, port stays free
        go_idle();
        step();
        chk("R2 idle grant", int'(grant), 0);
        chk("R2 idle valid", int'(owner_valid), 0);

        // R1 / R2 / R3 / R11: every request mask on a free port
        for (int p = 1; p < (1 << N); p++) begin
            go_idle();
            req = N'(p);
            step();
            chk("R1 R2 winner grant", int'(grant), 1 << low_bit(N'(p)));
            chk("R3 owner index", int'(owner_idx), low_bit(N'(p)));
            chk("R3 owner valid", int'(owner_valid), 1);
            chk("R11 reversed winner", int'(grant_inv), 1 << high_bit(N'(p)));
        end

        // R4: no done, owner holds against all others
        for (int o = 0; o < N; o++) begin
            acquire(o);
            req = '1; xfer_done = 1'b0;
            for (int c = 0; c < 3; c++) begin
                step();
                chk("R4 hold without done", int'(grant), 1 << o);
            end
        end

        // R5: higher requester takes over at a single-transfer end, one bubble
        for (int o = 1; o < N; o++) begin
            for (int h = 1; h < (1 << o); h++) begin
                acquire(o);
                req = N'((1 << o) | h); xfer_done = 1'b1;
                step();
                chk("R5 bubble grant", int'(grant), 0);
                chk("R5 bubble valid", int'(owner_valid), 0);
                xfer_done = 1'b0;
                step();
                chk("R5 new owner", int'(grant), 1 << low_bit(N'(h)));
            end
        end

        // R6: highest owner runs back to back
        acquire(0);
        req = '1; xfer_done = 1'b1;
        for (int c = 0; c < 4; c++) begin
            step();
            chk("R6 back to back", int'(grant), 1);
        end

        // R7: lower requester waits until owner stops
        acquire(1);
        req = 3'b110; xfer_done = 1'b1;
        for (int c = 0; c < 3; c++) begin
            step();
            chk("R7 lower waits", int'(grant), 2);
        end
        req = 3'b100;
        step();
        chk("R7 release bubble", int'(owner_valid), 0);
        xfer_done = 1'b0;
        step();
        chk("R7 waiting master granted", int'(grant), 4);

        // R8: bursts of 2..5 beats by the lowest-ranked master are not broken
        for (int L = 2; L <= 5; L++) begin
            acquire(2);
            burst_len = '0;
            burst_len[2*LEN_W +: LEN_W] = LEN_W'(L);
            req = '1; burst_start = 3'b100; xfer_done = 1'b1;
            step();
            burst_start = '0;
            chk("R8 after first beat", int'(grant), 4);
            xfer_done = 1'b0;
            step();
            chk("R8 wait inside burst", int'(grant), 4);
            xfer_done = 1'b1;
            for (int b = 2; b < L; b++) begin
                step();
                chk("R8 middle beat", int'(grant), 4);
            end
            step();
            chk("R8 release after last beat", int'(owner_valid), 0);
            xfer_done = 1'b0;
            step();
            chk("R8 next owner", int'(grant), 1);
        end

        // R9: lengths 0 and 1 behave as single transfers
        for (int L = 0; L < 2; L++) begin
            acquire(2);
            burst_len = '0;
            burst_len[2*LEN_W +: LEN_W] = LEN_W'(L);
            req = 3'b101; burst_start = 3'b100; xfer_done = 1'b1;
            step();
            chk("R9 short burst released", int'(owner_valid), 0);
            burst_start = '0; xfer_done = 1'b0;
            step();
            chk("R9 next owner", int'(grant), 1);
        end

        go_idle();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule